// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches eight external request pins on behalf of a microcontroller peripheral bus. Each pin first goes through a two-stage synchroniser. A per-pin detector, programmed to look for a low level, a high level, a rising edge or a falling edge, then raises an event. Every event sets a sticky per-channel request flag.

A channel forwards its flag as a request only while its enable bit is set. The OR of all forwarded requests forms a single interrupt line. Software services a channel and then removes its flag by writing a 0 to that bit position; a 1 in the written value leaves the bit as it is. A read that belongs to a read-modify-write sequence sees the flag register as all ones, so the write-back half of that sequence clears nothing.

A flag keeps setting for as long as a level-mode pin stays active. If a new event and a clearing write reach the same channel in the same cycle, the event wins, so no request is lost.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A read at address 0 returns the flag register. Bit i is 1 exactly when channel i has a pending request.
- R2: A write at address 0 clears flag bit i when data bit i is 0, as long as no event for channel i arrives in that same cycle.
- R3: A write at address 0 leaves flag bit i unchanged when data bit i is 1.
- R4: A read at address 0 with the read-modify-write qualifier high returns 8'hFF, whatever the flags hold.
- R5: In a level mode, a flag whose pin stays at the active level is still set after a clearing write.
- R6: When a detection event and a clearing write hit the same channel in the same cycle, the flag ends up set.
- R7: Flags set whether or not the channel is enabled. `req_o[i]` equals flag i AND enable bit i, and `irq_o` is the OR of `req_o`.
- R8: The enable register is at address 1. Mode for pin i sits in bits 2i+1:2i of a 16-bit mode register. Pins 0–3 are in the low byte (address 2) and pins 4–7 in the high byte (address 3). The mode codes are 00 low level, 01 high level, 10 rising edge, 11 falling edge. All of these registers read back what was written.
- R9: A pin level first sampled at clock edge k produces its event after two synchroniser stages, so the flag is set at edge k+2. An edge mode sets the flag once per matching edge and ignores the opposite edge.
- R10: While reset is high, the flag, enable and mode registers are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous external request pins |
| bus_addr | input | 2 | Register select: 0 flags, 1 enable, 2 mode low, 3 mode high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rmw | input | 1 | Marks the current read as part of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| req_o | output | 8 | Per-channel request (flag AND enable) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that bus inputs and pins hold steady across each rising edge. They also assume that the mode of an edge-mode channel changes only through a bus write. The bench drives every input at the falling edge. Pins change only a few bits at a time, and writes fall at random onto all four addresses, including mode changes while pins are active. Each check is made one nanosecond after the drive, against a reference model that is updated on the rising edge. The set-versus-clear collision is placed on a computed cycle so that it hits the edge where the event lands.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int NUM_CH    = 8;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int SYNC_LEN  = 2;
    localparam int MODE_W    = 2 * NUM_CH;
    localparam int PINS_BYTE = DATA_W / 2;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG    = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_MODE_LO = 2'd2,
        REG_MODE_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_hist_t;

    function automatic logic detect_hit(det_mode_e m, pin_hist_t h);
        case (m)
            DET_LOW:  return !h.cur;
            DET_HIGH: return h.cur;
            DET_RISE: return h.cur && !h.prev;
            default:  return !h.cur && h.prev;
        endcase
    endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int N      = ext_irq_pkg::NUM_CH,
    parameter int STAGES = ext_irq_pkg::SYNC_LEN
) (
    input  logic         clk,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] stage_q;

    always_ff @(posedge clk) stage_q[0] <= pin_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic      [N-1:0]     sync_i,
    input  det_mode_e [N-1:0]     mode_i,
    output logic      [N-1:0]     evt_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) prev_q <= sync_i;

    for (genvar i = 0; i < N; i++) begin : g_ch
        pin_hist_t hist;
        assign hist     = '{cur: sync_i[i], prev: prev_q[i]};
        assign evt_o[i] = detect_hit(mode_i[i], hist);

        AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
            (evt_o[i] && mode_i[i][1]) |=> (!evt_o[i] || !$stable(mode_i[i]))); // R9
    end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rmw,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_CH-1:0]     evt_i,
    output logic [DATA_W-1:0]     bus_rdata,
    output det_mode_e [NUM_CH-1:0] mode_o,
    output logic [NUM_CH-1:0]     req_o
);
    reg_sel_e            sel;
    logic [NUM_CH-1:0]   flag_q, en_q, clr_mask;
    logic [MODE_W-1:0]   mode_q;

    assign sel      = reg_sel_e'(bus_addr);
    assign clr_mask = (bus_wr && sel == REG_FLAG) ? ~bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            mode_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | evt_i;
            if (bus_wr) begin
                case (sel)
                    REG_ENABLE:  en_q <= bus_wdata;
                    REG_MODE_LO: mode_q[DATA_W-1:0] <= bus_wdata;
                    REG_MODE_HI: mode_q[MODE_W-1:DATA_W] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_mode
        assign mode_o[i] = det_mode_e'(mode_q[2*i+1:2*i]);
    end

    always_comb begin
        case (sel)
            REG_FLAG:    bus_rdata = bus_rmw ? '1 : flag_q;
            REG_ENABLE:  bus_rdata = en_q;
            REG_MODE_LO: bus_rdata = mode_q[DATA_W-1:0];
            default:     bus_rdata = mode_q[MODE_W-1:DATA_W];
        endcase
    end

    assign req_o = flag_q & en_q;

    AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0)); // R1
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_FLAG) |=> ((flag_q & ~$past(bus_wdata) & ~$past(evt_i)) == '0)); // R2
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_FLAG) |=> ((~flag_q & $past(flag_q) & $past(bus_wdata)) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt_i) & ~flag_q) == '0)); // R6
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rmw,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] req_o,
    output logic              irq_o
);
    logic      [NUM_CH-1:0] pin_sync, evt;
    det_mode_e [NUM_CH-1:0] mode;

    ext_irq_sync #(.N(NUM_CH), .STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .pin_i  (pin_i),
        .sync_o (pin_sync)
    );

    ext_irq_detect #(.N(NUM_CH)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .sync_i (pin_sync),
        .mode_i (mode),
        .evt_o  (evt)
    );

    ext_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rmw   (bus_rmw),
        .bus_wdata (bus_wdata),
        .evt_i     (evt),
        .bus_rdata (bus_rdata),
        .mode_o    (mode),
        .req_o     (req_o)
    );

    assign irq_o = |req_o;

    AST_RMW_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_rmw && bus_addr == REG_FLAG) |-> (bus_rdata == '1)); // R4
    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_ENABLE) |=> ((req_o & ~$past(bus_wdata)) == '0)); // R7
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_i = 8'hFF;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rmw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] req_o;
    logic       irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ext_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rmw(bus_rmw), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .req_o(req_o), .irq_o(irq_o)
    );

    // reference model built from the requirements
    logic [7:0]  m_s1, m_s2, m_prev, m_flag, m_en;
    logic [15:0] m_mode;

    function automatic logic [7:0] m_events();
        logic [7:0] e;
        for (int i = 0; i < 8; i++) begin
            case (m_mode[2*i +: 2])
                2'b00: e[i] = !m_s2[i];
                2'b01: e[i] = m_s2[i];
                2'b10: e[i] = m_s2[i] && !m_prev[i];
                default: e[i] = !m_s2[i] && m_prev[i];
            endcase
        end
        return e;
    endfunction

    function automatic logic [7:0] m_read(logic [1:0] a, logic rmw);
        case (a)
            2'd0: return rmw ? 8'hFF : m_flag;
            2'd1: return m_en;
            2'd2: return m_mode[7:0];
            default: return m_mode[15:8];
        endcase
    endfunction

    always @(posedge clk) begin
        logic [7:0] clr;
        clr = (bus_wr && bus_addr == 2'd0) ? ~bus_wdata : 8'h00;
        if (rst) begin
            m_flag <= 8'h00; m_en <= 8'h00; m_mode <= 16'h0000;
        end else begin
            m_flag <= (m_flag & ~clr) | m_events();
            if (bus_wr && bus_addr == 2'd1) m_en <= bus_wdata;
            if (bus_wr && bus_addr == 2'd2) m_mode[7:0] <= bus_wdata;
            if (bus_wr && bus_addr == 2'd3) m_mode[15:8] <= bus_wdata;
        end
        m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rmw = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [1:0] a, logic rmw, logic [7:0] exp);
        bus_addr = a; bus_rmw = rmw;
        #1;
        check(tag, bus_rdata, exp);
        bus_rmw = 1'b0;
    endtask

    initial begin
        idle(5);
        rd("R10", 2'd0, 1'b0, 8'h00);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        rd("R10", 2'd1, 1'b0, 8'h00);
        rd("R10", 2'd2, 1'b0, 8'h00);
        rd("R10", 2'd3, 1'b0, 8'h00);
        idle(3);
        rd("R1", 2'd0, 1'b0, 8'h00);

        // pins 4-7 high-level mode while pins are high
        wr(2'd3, 8'h55);
        idle(3);
        rd("R8", 2'd3, 1'b0, 8'h55);
        rd("R1", 2'd0, 1'b0, 8'hF0);
        wr(2'd0, 8'h00);
        rd("R5", 2'd0, 1'b0, 8'hF0);

        wr(2'd3, 8'h00);
        wr(2'd0, 8'h00);
        idle(2);
        rd("R2", 2'd0, 1'b0, 8'h00);

        // pin0 rising, pin1 falling, pins 2-3 low level
        wr(2'd2, 8'h0E);
        rd("R8", 2'd2, 1'b0, 8'h0E);
        pin_i = 8'hFE;
        idle(4);
        rd("R9", 2'd0, 1'b0, 8'h00);
        pin_i = 8'hFF;
        idle(4);
        rd("R9", 2'd0, 1'b0, 8'h01);
        check("R7", req_o, 8'h00);
        check("R7", {7'd0, irq_o}, 8'h00);
        wr(2'd1, 8'h01);
        rd("R8", 2'd1, 1'b0, 8'h01);
        check("R7", req_o, 8'h01);
        check("R7", {7'd0, irq_o}, 8'h01);

        wr(2'd0, 8'hFF);
        rd("R3", 2'd0, 1'b0, 8'h01);
        rd("R4", 2'd0, 1'b1, 8'hFF);
        rd("R1", 2'd0, 1'b0, 8'h01);
        wr(2'd0, 8'hFE);
        rd("R2", 2'd0, 1'b0, 8'h00);
        check("R7", {7'd0, irq_o}, 8'h00);

        pin_i = 8'hFD;
        idle(4);
        rd("R9", 2'd0, 1'b0, 8'h02);
        wr(2'd0, 8'h00);
        idle(3);
        rd("R9", 2'd0, 1'b0, 8'h00);

        // collision: rising event on pin0 meets a clearing write
        pin_i = 8'hFE;
        idle(4);
        wr(2'd0, 8'h00);
        @(negedge clk); pin_i = 8'hFF;
        @(negedge clk);
        @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd("R6", 2'd0, 1'b0, 8'h01);

        // constrained random phase
        void'($urandom(32'h1234_5678));
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) pin_i[$urandom_range(0, 7)] ^= 1'b1;
            bus_wr    = ($urandom_range(0, 3) == 0);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = 8'($urandom);
            bus_rmw   = ($urandom_range(0, 7) == 0);
            #1;
            check("R1", bus_rdata, m_read(bus_addr, bus_rmw));
            check("R7", req_o, m_flag & m_en);
            check("R7", {7'd0, irq_o}, {7'd0, |(m_flag & m_en)});
        end
        @(negedge clk); bus_wr = 1'b0; bus_rmw = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule